// File: doc/BRIEF.md
# Static Memory Bus Cycle Generator with External Wait

This block turns single requests from an internal master into asynchronous static-memory bus cycles on one chip select. Each access runs through three phases. In the setup phase the address and byte selects are driven. In the pulse phase the read or write strobe is held low. In the hold phase the strobe is high again while the address stays put. The length of each phase, in clock cycles, comes from configuration inputs, with separate values for reads and for writes.

A slow device can stretch the pulse phase through an active-low wait input. A two-bit mode field controls how that input acts. With the wait function off, the input is ignored. In frozen mode, the phase counter stops while wait is low. In ready mode, the pulse phase cannot end while wait is low.

After a read, the device may keep driving the data bus for a programmable data-float time. Any float time that the read hold phase does not already cover is added as idle wait states before the next access is accepted.

The FSM has five states:
- IDLE: ready for a request.
- SETUP: address valid, strobe high.
- PULSE: strobe low, wait input evaluated.
- HOLD: strobe high, address held.
- FLOAT: read recovery.

It has these transitions:
- IDLE→SETUP when a request is accepted and setup is nonzero.
- IDLE→PULSE when a request is accepted and setup is zero.
- SETUP→PULSE when the setup count runs out.
- PULSE→HOLD when the pulse is done and hold is nonzero.
- PULSE→FLOAT when the pulse is done, hold is zero and float cycles remain after a read.
- PULSE→IDLE when the pulse is done and there is nothing else to do.
- HOLD→FLOAT when hold runs out and float cycles remain after a read.
- HOLD→IDLE when hold runs out and there is nothing else to do.
- FLOAT→IDLE when the float count runs out.

Top module: `ebus_cycle_gen`

## Requirements
- R1: Out of reset and whenever idle, `req_ready` is 1, both strobes are high (1), `bus_doe` is 0 and every bit of `bus_nbs` is 1.
- R2: An accepted access gives exactly S setup cycles, then max(P,1) pulse cycles, then H hold cycles. S may be 0. The read strobe goes low for a read (`req_write`=0) and the write strobe for a write (`req_write`=1). `req_ready` returns in the cycle after the last hold cycle if no float cycles follow.
- R3: During a write, `bus_doe` is 1 for exactly S+max(P,1)+H cycles and is never 1 during a read. During the pulse, `bus_dout` equals the write data, `bus_addr` equals the request address, and `bus_nbs` equals the bitwise inverse of `req_be`.
- R4: A read captures `bus_din` on its last pulse cycle into `rsp_rdata`. `rsp_valid` is 1 for exactly one cycle afterwards.
- R5: Wait mode 2'b00 (off) and 2'b01 (reserved) ignore `nwait_in` completely.
- R6: Wait mode 2'b10 (frozen) stops the pulse counter in every cycle in which the synchronized wait is low, so the pulse grows by the number of such cycles.
- R7: Wait mode 2'b11 (ready) keeps counting while wait is low. The pulse only ends once the count has expired and the synchronized wait is high. A wait that is released before expiry adds nothing.
- R8: `nwait_in` passes through two flops, so a level driven before clock edge k acts in the cycle after edge k+1. It is evaluated only in the pulse phase. A low seen during setup or hold changes no phase length.
- R9: After a read, max(TDF−H,0) float cycles follow the hold phase before `req_ready` returns. With TDF=5 and read hold 1 this gives 4 wait states. A write adds none.
- R10: `cfg_err` is 1 when the wait mode is 2'b10 or 2'b11 and the read hold or the write hold is 0. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, active high |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | DATA_W | Captured read data |
| cfg_rd_setup | input | CNT_W | Read setup cycles |
| cfg_rd_pulse | input | CNT_W | Read pulse cycles (0 acts as 1) |
| cfg_rd_hold | input | CNT_W | Read hold cycles |
| cfg_wr_setup | input | CNT_W | Write setup cycles |
| cfg_wr_pulse | input | CNT_W | Write pulse cycles (0 acts as 1) |
| cfg_wr_hold | input | CNT_W | Write hold cycles |
| cfg_wait_mode | input | 2 | External wait mode |
| cfg_tdf | input | CNT_W | Data-float cycles after a read |
| cfg_err | output | 1 | Wait enabled with a zero hold count |
| nwait_in | input | 1 | External wait, active low, asynchronous |
| bus_addr | output | ADDR_W | Bus address |
| bus_dout | output | DATA_W | Bus write data |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | DATA_W | Bus read data |
| bus_nbs | output | DATA_W/8 | Byte selects, active low |
| bus_nrd | output | 1 | Read strobe, active low |
| bus_nwe | output | 1 | Write strobe, active low |

## Verification
The bench uses the default parameters: a 24-bit address, a 16-bit data bus with two byte lanes and 4-bit phase counters. The counters reach a float count of 5, pulse lengths of 4 and setup lengths of 3, which are enough to place a wait window fully inside the pulse, across its expiry, or entirely in setup or hold. That makes the difference between frozen and ready modes visible as a one-cycle difference in pulse length. The 16-bit data bus lets a read drive a different value on each pulse cycle, which proves that capture happens on the last one.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_PULSE = 3'd2,
        ST_HOLD  = 3'd3,
        ST_FLOAT = 3'd4
    } bus_state_e;

    localparam logic [1:0] WM_OFF    = 2'b00;
    localparam logic [1:0] WM_RSVD   = 2'b01;
    localparam logic [1:0] WM_FROZEN = 2'b10;
    localparam logic [1:0] WM_READY  = 2'b11;

endpackage

// File: rtl/ebus_sync.sv
module ebus_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_in};
        end
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/ebus_fsm.sv
module ebus_fsm
    import ebus_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [CNT_W-1:0] rd_setup,
    input  logic [CNT_W-1:0] rd_pulse,
    input  logic [CNT_W-1:0] rd_hold,
    input  logic [CNT_W-1:0] wr_setup,
    input  logic [CNT_W-1:0] wr_pulse,
    input  logic [CNT_W-1:0] wr_hold,
    input  logic [1:0]       wait_mode,
    input  logic [CNT_W-1:0] tdf,
    input  logic             nwait_s,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             rsp_valid,
    output logic             in_cycle,
    output logic             strobe_rd_n,
    output logic             strobe_wr_n,
    output logic             drive_en
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    bus_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wr_q;

    logic             wr_sel;
    logic [CNT_W-1:0] s_cnt, p_cnt, h_cnt, p_m1, float_len;
    logic             wait_en, frozen, stall, pulse_done, float_pending;

    // Selected phase counts: at accept use the incoming direction.
    always_comb begin
        wr_sel    = (state_q == ST_IDLE) ? req_write : wr_q;
        s_cnt     = wr_sel ? wr_setup : rd_setup;
        p_cnt     = wr_sel ? wr_pulse : rd_pulse;
        h_cnt     = wr_sel ? wr_hold  : rd_hold;
        p_m1      = (p_cnt == CNT_ZERO) ? CNT_ZERO : p_cnt - CNT_ONE;
        float_len = (tdf > rd_hold) ? tdf - rd_hold : CNT_ZERO;
    end

    assign wait_en       = wait_mode[1];
    assign frozen        = (wait_mode == WM_FROZEN);
    assign stall         = wait_en && !nwait_s;
    assign pulse_done    = (cnt_q == CNT_ZERO) && !stall;
    assign float_pending = !wr_q && (float_len != CNT_ZERO);
    assign accept        = (state_q == ST_IDLE) && req_valid;
    assign capture       = (state_q == ST_PULSE) && pulse_done && !wr_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (s_cnt != CNT_ZERO) begin
                        state_d = ST_SETUP;
                        cnt_d   = s_cnt - CNT_ONE;
                    end else begin
                        state_d = ST_PULSE;
                        cnt_d   = p_m1;
                    end
                end
            end
            ST_SETUP: begin
                if (cnt_q == CNT_ZERO) begin
                    state_d = ST_PULSE;
                    cnt_d   = p_m1;
                end else begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            ST_PULSE: begin
                if (pulse_done) begin
                    if (h_cnt != CNT_ZERO) begin
                        state_d = ST_HOLD;
                        cnt_d   = h_cnt - CNT_ONE;
                    end else if (float_pending) begin
                        state_d = ST_FLOAT;
                        cnt_d   = float_len - CNT_ONE;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else if (!(frozen && stall) && cnt_q != CNT_ZERO) begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            ST_HOLD: begin
                if (cnt_q == CNT_ZERO) begin
                    if (float_pending) begin
                        state_d = ST_FLOAT;
                        cnt_d   = float_len - CNT_ONE;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            ST_FLOAT: begin
                if (cnt_q == CNT_ZERO) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= CNT_ZERO;
            wr_q      <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            rsp_valid <= capture;
            if (accept) begin
                wr_q <= req_write;
            end
        end
    end

    // Output decode
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        in_cycle    = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);
        strobe_rd_n = !((state_q == ST_PULSE) && !wr_q);
        strobe_wr_n = !((state_q == ST_PULSE) && wr_q);
        drive_en    = in_cycle && wr_q;
    end

    p_rsp_after_read_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(state_q) == ST_PULSE) && !wr_q);

    p_wait_off_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && cnt_q == CNT_ZERO && !wait_en) |=> (state_q != ST_PULSE));

    p_frozen_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && frozen && !nwait_s) |=> (state_q == ST_PULSE) && $stable(cnt_q));

    p_ready_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && cnt_q == CNT_ZERO && wait_en && nwait_s) |=> (state_q != ST_PULSE));

    p_float_read_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLOAT) |-> !wr_q);
endmodule

// File: rtl/ebus_cycle_gen.sv
module ebus_cycle_gen
    import ebus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [CNT_W-1:0]  cfg_rd_setup,
    input  logic [CNT_W-1:0]  cfg_rd_pulse,
    input  logic [CNT_W-1:0]  cfg_rd_hold,
    input  logic [CNT_W-1:0]  cfg_wr_setup,
    input  logic [CNT_W-1:0]  cfg_wr_pulse,
    input  logic [CNT_W-1:0]  cfg_wr_hold,
    input  logic [1:0]        cfg_wait_mode,
    input  logic [CNT_W-1:0]  cfg_tdf,
    output logic              cfg_err,
    input  logic              nwait_in,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    output logic [BE_W-1:0]   bus_nbs,
    output logic              bus_nrd,
    output logic              bus_nwe
);
    logic              nwait_s;
    logic              accept, capture, in_cycle;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [BE_W-1:0]   be_q;

    ebus_sync #(.STAGES(2), .RST_VAL(1'b1)) u_wait_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (nwait_in),
        .q_out (nwait_s)
    );

    ebus_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .rd_setup    (cfg_rd_setup),
        .rd_pulse    (cfg_rd_pulse),
        .rd_hold     (cfg_rd_hold),
        .wr_setup    (cfg_wr_setup),
        .wr_pulse    (cfg_wr_pulse),
        .wr_hold     (cfg_wr_hold),
        .wait_mode   (cfg_wait_mode),
        .tdf         (cfg_tdf),
        .nwait_s     (nwait_s),
        .req_ready   (req_ready),
        .accept      (accept),
        .capture     (capture),
        .rsp_valid   (rsp_valid),
        .in_cycle    (in_cycle),
        .strobe_rd_n (bus_nrd),
        .strobe_wr_n (bus_nwe),
        .drive_en    (bus_doe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end
            if (capture) begin
                rdata_q <= bus_din;
            end
        end
    end

    always_comb begin
        bus_addr  = addr_q;
        bus_dout  = wdata_q;
        bus_nbs   = in_cycle ? ~be_q : {BE_W{1'b1}};
        rsp_rdata = rdata_q;
        cfg_err   = cfg_wait_mode[1] &&
                    ((cfg_rd_hold == '0) || (cfg_wr_hold == '0));
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> bus_nrd && bus_nwe && !bus_doe && (bus_nbs == {BE_W{1'b1}}));

    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_nrd && !bus_nwe));

    p_no_contention_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_doe && !bus_nrd));
endmodule

// File: tb/ebus_cycle_gen_tb.sv
module ebus_cycle_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 4;
    localparam int BE_W   = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [BE_W-1:0]   req_be = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic [CNT_W-1:0]  rd_s = 4'd1, rd_p = 4'd1, rd_h = 4'd1;
    logic [CNT_W-1:0]  wr_s = 4'd1, wr_p = 4'd1, wr_h = 4'd1;
    logic [1:0]        wmode = 2'b00;
    logic [CNT_W-1:0]  tdf = 4'd0;
    logic              cfg_err;
    logic              nwait_in = 1'b1;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_dout;
    logic              bus_doe;
    logic [DATA_W-1:0] bus_din = '0;
    logic [BE_W-1:0]   bus_nbs;
    logic              bus_nrd, bus_nwe;

    int vectors = 0;
    int miscompares = 0;

    // results of the last access
    int n_setup, n_pulse, n_tail, n_doe, n_rsp, n_busbad;

    always #(CLK_PERIOD/2) clk = ~clk;

    ebus_cycle_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cfg_rd_setup(rd_s), .cfg_rd_pulse(rd_p), .cfg_rd_hold(rd_h),
        .cfg_wr_setup(wr_s), .cfg_wr_pulse(wr_p), .cfg_wr_hold(wr_h),
        .cfg_wait_mode(wmode), .cfg_tdf(tdf), .cfg_err(cfg_err),
        .nwait_in(nwait_in),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .bus_nbs(bus_nbs), .bus_nrd(bus_nrd), .bus_nwe(bus_nwe)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One access; wait low driven at negedges of cycles ws..ws+wl-1 (cycle 1 = first after accept).
    task automatic run_access(input logic wr, input logic [ADDR_W-1:0] a,
                              input logic [DATA_W-1:0] d, input logic [BE_W-1:0] be,
                              input int ws, input int wl);
        bit seen_low;
        int pidx;
        n_setup = 0; n_pulse = 0; n_tail = 0; n_doe = 0; n_rsp = 0; n_busbad = 0;
        seen_low = 0; pidx = 0;
        @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
        @(posedge clk);
        for (int j = 1; j < 100; j++) begin
            @(negedge clk);
            req_valid = 1'b0;
            nwait_in  = !(j >= ws && j < ws + wl);
            if (rsp_valid) n_rsp++;
            if (bus_doe) n_doe++;
            if (req_ready) break;
            if ((wr ? bus_nwe : bus_nrd) == 1'b0) begin
                seen_low = 1;
                n_pulse++;
                if (wr && (bus_dout != d || bus_addr != a || bus_nbs != ~be)) n_busbad++;
                if (!wr) begin
                    bus_din = d + DATA_W'(pidx);
                    if (bus_addr != a || bus_nbs != ~be) n_busbad++;
                end
                pidx++;
            end else begin
                bus_din = '0;
                if (seen_low) n_tail++;
                else n_setup++;
            end
        end
        nwait_in = 1'b1;
        // allow a trailing rsp_valid to be seen
        @(negedge clk);
        if (rsp_valid) n_rsp++;
    endtask

    task automatic t_reset();
        check("R1", "ready", req_ready, 1);
        check("R1", "nrd", bus_nrd, 1);
        check("R1", "nwe", bus_nwe, 1);
        check("R1", "doe", bus_doe, 0);
        check("R1", "nbs", bus_nbs, 3);
    endtask

    task automatic t_write_basic();
        wr_s = 2; wr_p = 3; wr_h = 1; wmode = 2'b00; tdf = 5;
        run_access(1'b1, 24'h12_3456, 16'hBEEF, 2'b01, 0, 0);
        check("R2", "write setup", n_setup, 2);
        check("R2", "write pulse", n_pulse, 3);
        check("R9", "write tail no float", n_tail, 1);
        check("R3", "doe cycles", n_doe, 6);
        check("R3", "bus fields", n_busbad, 0);
        check("R1", "idle after write nbs", bus_nbs, 3);
    endtask

    task automatic t_read_basic();
        rd_s = 1; rd_p = 3; rd_h = 2; tdf = 0; wmode = 2'b00;
        run_access(1'b0, 24'h00_0ABC, 16'h1000, 2'b11, 0, 0);
        check("R2", "read setup", n_setup, 1);
        check("R2", "read pulse", n_pulse, 3);
        check("R2", "read tail", n_tail, 2);
        check("R3", "no doe on read", n_doe, 0);
        check("R4", "rdata last pulse", rsp_rdata, 16'h1002);
        check("R4", "rsp pulses", n_rsp, 1);
        check("R3", "read bus fields", n_busbad, 0);
    endtask

    task automatic t_zero_phases();
        wr_s = 0; wr_p = 0; wr_h = 0;
        run_access(1'b1, 24'h00_0001, 16'h5A5A, 2'b10, 0, 0);
        check("R2", "zero setup", n_setup, 0);
        check("R2", "zero pulse acts as one", n_pulse, 1);
        check("R2", "zero hold", n_tail, 0);
        check("R3", "doe zero phases", n_doe, 1);
    endtask

    task automatic t_float();
        rd_s = 1; rd_p = 2; rd_h = 1; tdf = 5; wmode = 2'b00;
        run_access(1'b0, 24'h00_0002, 16'h2000, 2'b11, 0, 0);
        check("R9", "hold plus 4 float", n_tail, 5);
        rd_h = 2; tdf = 1;
        run_access(1'b0, 24'h00_0003, 16'h3000, 2'b11, 0, 0);
        check("R9", "float covered by hold", n_tail, 2);
        tdf = 0;
    endtask

    task automatic t_wait_modes();
        rd_s = 1; rd_p = 4; rd_h = 1; tdf = 0;
        wmode = 2'b00;
        run_access(1'b0, 24'h00_0010, 16'h4000, 2'b11, 2, 2);
        check("R5", "mode off pulse", n_pulse, 4);
        wmode = 2'b01;
        run_access(1'b0, 24'h00_0011, 16'h4100, 2'b11, 2, 2);
        check("R5", "mode reserved pulse", n_pulse, 4);
        wmode = 2'b10;
        run_access(1'b0, 24'h00_0012, 16'h4200, 2'b11, 2, 2);
        check("R6", "frozen pulse", n_pulse, 6);
        check("R6", "frozen rdata", rsp_rdata, 16'h4205);
        wmode = 2'b11;
        run_access(1'b0, 24'h00_0013, 16'h4300, 2'b11, 2, 2);
        check("R7", "ready pulse held at expiry", n_pulse, 5);
        run_access(1'b0, 24'h00_0014, 16'h4400, 2'b11, 1, 1);
        check("R7", "ready early release no extension", n_pulse, 4);
    endtask

    task automatic t_wait_outside();
        wmode = 2'b10; tdf = 0;
        rd_s = 3; rd_p = 2; rd_h = 1;
        run_access(1'b0, 24'h00_0020, 16'h5000, 2'b11, 1, 1);
        check("R8", "wait in setup setup len", n_setup, 3);
        check("R8", "wait in setup pulse len", n_pulse, 2);
        rd_s = 1; rd_p = 2; rd_h = 3;
        run_access(1'b0, 24'h00_0021, 16'h5100, 2'b11, 3, 1);
        check("R8", "wait in hold pulse len", n_pulse, 2);
        check("R8", "wait in hold hold len", n_tail, 3);
        rd_h = 1;
        run_access(1'b0, 24'h00_0022, 16'h5200, 2'b11, 2, 1);
        check("R8", "sync latency pushes wait past pulse", n_pulse, 2);
    endtask

    task automatic t_cfg_err();
        rd_h = 1; wr_h = 1; wmode = 2'b10;
        #1 check("R10", "err clear", cfg_err, 0);
        wr_h = 0;
        #1 check("R10", "err wr hold 0", cfg_err, 1);
        wmode = 2'b11; wr_h = 1; rd_h = 0;
        #1 check("R10", "err rd hold 0", cfg_err, 1);
        wmode = 2'b00;
        #1 check("R10", "err wait off", cfg_err, 0);
        rd_h = 1;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        miscompares++;
        vectors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_basic();
        t_read_basic();
        t_zero_phases();
        t_float();
        t_wait_modes();
        t_wait_outside();
        t_cfg_err();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule